// File: doc/BRIEF.md
# Protected Fuse Shadow Cache

This block keeps a register copy of a one-time-programmable fuse array organised as several banks. Each bank holds a number of 8-bit rows and one protection byte. After reset the block pulls the whole array in over a valid/ready load stream. Each beat carries one byte and a stored parity bit. Only when the load is complete does the block open its register port to software.

Software reaches the cache through a 32-bit register port. A request is presented with `req_valid` and taken when `req_ready` is high. Its response appears on the next cycle as a one-cycle `rsp_valid` pulse. That response has no back-pressure: the requester must take it in the cycle it is shown. Through this port software can read rows, override rows, read each bank's protection byte, and read or clear a shared sticky error register.

Every access is checked against the selected bank's protection byte. A violation is recorded as an error bit, and the access itself never stalls. Overrides change only the cached copy and persist until the next hard reset, which reloads the array.

Top module: `fsc_shadow_cache`

## Requirements
- R1: While reset is held, and until the load has finished, `req_ready` is 0 and `ld_ready` is 1; `rsp_valid` is 0 after reset. The load finishes once BANKS*(ROWS+1) beats have been accepted, a beat being accepted when `ld_valid` and `ld_ready` are both high. From then on `ld_ready` stays 0 and `req_ready` stays 1.
- R2: Load beats arrive bank by bank, starting at bank 0. For each bank the protection byte comes first, followed by rows 0 to ROWS-1. `ld_par` is stored with each row and ignored on protection beats.
- R3: A request is accepted when `req_valid` and `req_ready` are both high. Exactly one cycle later `rsp_valid` is high for one cycle and `rsp_rdata` holds the read data, or zero for a write. With no accepted request, `rsp_valid` is 0.
- R4: The address space has four kinds of location. Word address 0 is the error register. Address BANKS+b holds the protection byte of bank b. Address (1<<(log2 ROWS+log2 BANKS)) + b*ROWS + r holds row r of bank b, returned in bits 7:0 with the upper bits zero. Every other address reads as zero.
- R5: A row read from a bank whose protection bit 5 (read-protect) is set returns zero data and sets error bit 4. On a bank without read-protect the cached value is returned.
- R6: A row write to a bank whose protection bit 6 (override-protect) is set is refused, leaving the row unchanged, and sets error bit 5.
- R7: An accepted row write replaces the cached value and its parity bit. The new value holds until the next reset.
- R8: Each row is stored with a parity bit chosen so that the XOR of the 8 data bits and the parity bit is 0. An unprotected row read that finds a mismatch sets error bit 1 and still returns the cached data.
- R9: A write to a protection byte or to an unmapped address changes nothing and sets error bit 3.
- R10: The error register is sticky and write-one-to-clear: a write to address 0 clears exactly the bits written as 1. Only bits 1, 3, 4 and 5 exist; every other bit reads 0.
- R11: Protection bits 7 (write-protect) and 3 (sense-protect) have no effect on row reads or row writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load beat present |
| ld_ready | output | 1 | Block accepts load beats (high until load complete) |
| ld_data | input | 8 | Load byte (protection byte or row) |
| ld_par | input | 1 | Stored parity bit for a row beat |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register port open (load complete) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |

## Verification
The bench builds the block with ROWS=8, BANKS=4 and ADDR_W=7. Four banks give each protection case a bank of its own: one bank is unprotected, one is override-protected, one is read-protected, and one carries only the write-protect and sense-protect bits. The 7-bit address leaves an unmapped upper half above the row window, and that half is exercised. Eight rows keep the load to 36 beats, so the load can run with gaps on `ld_valid` and still leave room for back-to-back requests afterwards.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int PROT_WP = 7;
  localparam int PROT_OP = 6;
  localparam int PROT_RP = 5;
  localparam int PROT_SP = 3;

  localparam int ERR_PAR  = 1;
  localparam int ERR_LOCK = 3;
  localparam int ERR_RP   = 4;
  localparam int ERR_OP   = 5;
  localparam logic [7:0] ERR_MASK = 8'h3A;

  typedef enum logic [1:0] {
    LOC_ERR,
    LOC_PROT,
    LOC_ROW,
    LOC_NONE
  } loc_kind_e;
endpackage

// File: rtl/fsc_loader.sv
module fsc_loader #(
  parameter int BANKS = 2,
  parameter int ROWS  = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int SLOT_W = $clog2(ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  output logic              done,
  output logic              beat,
  output logic              beat_prot,
  output logic [BANK_W-1:0] beat_bank,
  output logic [ROW_W-1:0]  beat_row
);
  logic [BANK_W-1:0] bank_q;
  logic [SLOT_W-1:0] slot_q;
  logic              done_q;
  logic [SLOT_W-1:0] slot_m1;

  assign ld_ready  = !done_q;
  assign done      = done_q;
  assign beat      = ld_valid && !done_q;
  assign beat_prot = (slot_q == '0);
  assign beat_bank = bank_q;
  assign slot_m1   = slot_q - SLOT_W'(1);
  assign beat_row  = slot_m1[ROW_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      slot_q <= '0;
      done_q <= 1'b0;
    end else if (beat) begin
      if (slot_q == SLOT_W'(ROWS)) begin
        slot_q <= '0;
        if (bank_q == BANK_W'(BANKS - 1)) done_q <= 1'b1;
        else bank_q <= bank_q + BANK_W'(1);
      end else begin
        slot_q <= slot_q + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fsc_bank_store.sv
module fsc_bank_store #(
  parameter int ROWS = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_we,
  input  logic             row_we,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [7:0]       wr_data,
  input  logic             wr_par,
  input  logic [ROW_W-1:0] rd_row,
  output logic [7:0]       rd_data,
  output logic             rd_par,
  output logic [7:0]       prot
);
  logic [7:0] prot_q;
  logic [7:0] data_q [ROWS];
  logic       par_q  [ROWS];

  assign prot    = prot_q;
  assign rd_data = data_q[rd_row];
  assign rd_par  = par_q[rd_row];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_q <= '0;
    else if (prot_we) prot_q <= wr_data;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[r] <= '0;
        par_q[r]  <= 1'b0;
      end else if (row_we && wr_row == ROW_W'(r)) begin
        data_q[r] <= wr_data;
        par_q[r]  <= wr_par;
      end
    end
  end
endmodule

// File: rtl/fsc_err_reg.sv
module fsc_err_reg
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set_vec,
  input  logic       clr_we,
  input  logic [7:0] clr_vec,
  output logic [7:0] err
);
  logic [7:0] err_q;
  logic [7:0] clr_eff;

  assign clr_eff = clr_we ? clr_vec : 8'h00;
  assign err     = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else err_q <= ((err_q & ~clr_eff) | set_vec) & ERR_MASK;
  end
endmodule

// File: rtl/fsc_shadow_cache.sv
module fsc_shadow_cache
  import fsc_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int ROWS   = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [7:0]        ld_data,
  input  logic              ld_par,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int ROW_W   = $clog2(ROWS);
  localparam int BANK_W  = $clog2(BANKS);
  localparam int ROW_BIT = ROW_W + BANK_W;

  logic              load_done, ld_beat, ld_is_prot;
  logic [BANK_W-1:0] ld_bank;
  logic [ROW_W-1:0]  ld_row;

  fsc_loader #(.BANKS(BANKS), .ROWS(ROWS)) u_loader (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .done(load_done), .beat(ld_beat), .beat_prot(ld_is_prot),
    .beat_bank(ld_bank), .beat_row(ld_row)
  );

  logic              acc;
  loc_kind_e         kind;
  logic [BANK_W-1:0] sel_bank;
  logic [ROW_W-1:0]  sel_row;

  assign acc       = req_valid && req_ready;
  assign req_ready = load_done;
  assign sel_row   = req_addr[ROW_W-1:0];

  always_comb begin
    kind     = LOC_NONE;
    sel_bank = req_addr[BANK_W-1:0];
    if (req_addr == '0) begin
      kind = LOC_ERR;
    end else if ((req_addr >> ROW_BIT) == ADDR_W'(1)) begin
      kind     = LOC_ROW;
      sel_bank = req_addr[ROW_BIT-1:ROW_W];
    end else if (req_addr >= ADDR_W'(BANKS) && req_addr < ADDR_W'(2 * BANKS)) begin
      kind = LOC_PROT;
    end
  end

  logic [7:0] prot_v [BANKS];
  logic [7:0] data_v [BANKS];
  logic       par_v  [BANKS];
  logic       ov_we;
  logic [ROW_W-1:0] wr_row;
  logic [7:0]       wr_data;
  logic             wr_par;

  assign wr_row  = load_done ? sel_row : ld_row;
  assign wr_data = load_done ? req_wdata[7:0] : ld_data;
  assign wr_par  = load_done ? ^req_wdata[7:0] : ld_par;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic prot_we_b, row_we_b;
    assign prot_we_b = ld_beat && ld_is_prot && ld_bank == BANK_W'(b);
    assign row_we_b  = (ld_beat && !ld_is_prot && ld_bank == BANK_W'(b)) ||
                       (ov_we && sel_bank == BANK_W'(b));
    fsc_bank_store #(.ROWS(ROWS)) u_store (
      .clk(clk), .rst_n(rst_n), .prot_we(prot_we_b), .row_we(row_we_b),
      .wr_row(wr_row), .wr_data(wr_data), .wr_par(wr_par), .rd_row(sel_row),
      .rd_data(data_v[b]), .rd_par(par_v[b]), .prot(prot_v[b])
    );
  end

  logic [7:0]        err_v;
  logic [7:0]        set_vec;
  logic              clr_we;
  logic [DATA_W-1:0] rd_word;
  logic [7:0]        cur_prot;

  assign cur_prot = prot_v[sel_bank];

  always_comb begin
    set_vec = '0;
    ov_we   = 1'b0;
    clr_we  = 1'b0;
    rd_word = '0;
    if (acc) begin
      unique case (kind)
        LOC_ERR: begin
          if (req_write) clr_we = 1'b1;
          else rd_word = DATA_W'(err_v);
        end
        LOC_PROT: begin
          if (req_write) set_vec[ERR_LOCK] = 1'b1;
          else rd_word = DATA_W'(cur_prot);
        end
        LOC_ROW: begin
          if (req_write) begin
            if (cur_prot[PROT_OP]) set_vec[ERR_OP] = 1'b1;
            else ov_we = 1'b1;
          end else if (cur_prot[PROT_RP]) begin
            set_vec[ERR_RP] = 1'b1;
          end else begin
            rd_word = DATA_W'(data_v[sel_bank]);
            if (^{data_v[sel_bank], par_v[sel_bank]}) set_vec[ERR_PAR] = 1'b1;
          end
        end
        default: begin
          if (req_write) set_vec[ERR_LOCK] = 1'b1;
        end
      endcase
    end
  end

  fsc_err_reg u_err (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_we(clr_we),
    .clr_vec(req_wdata[7:0]), .err(err_v)
  );

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^req_wdata[DATA_W-1:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/fsc_shadow_cache_chk.sv
module fsc_shadow_cache_chk
  import fsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              ld_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [7:0]        err_v
);
  logic acc_c;
  assign acc_c = req_valid && req_ready;

  a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_c |=> rsp_valid);
  a_r3_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_c |=> !rsp_valid);
  a_r3_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && req_write) |=> (rsp_rdata == '0));
  a_r1_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_ready && req_ready));
  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (err_v & ~ERR_MASK) == 8'h00);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_c && req_write && req_addr == '0) |=> ((err_v & $past(err_v)) == $past(err_v)));
endmodule

bind fsc_shadow_cache fsc_shadow_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .ld_ready(ld_ready),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_v(err_v)
);

// File: tb/fsc_shadow_cache_test.sv
`timescale 1ns/1ps
module fsc_shadow_cache_test;
  localparam int BANKS  = 4;
  localparam int ROWS   = 8;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam int RB     = $clog2(ROWS) + $clog2(BANKS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0, ld_par = 1'b0;
  logic [7:0] ld_data = '0;
  logic ld_ready, req_ready, rsp_valid;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [DATA_W-1:0] rsp_rdata;

  always #2.5 clk = ~clk;

  fsc_shadow_cache #(.BANKS(BANKS), .ROWS(ROWS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_data(ld_data), .ld_par(ld_par), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fdat(int b, int r);
    return 8'((b * 37 + r * 11 + 5) & 255);
  endfunction

  // behavioural reference model
  logic [7:0] m_prot [BANKS];
  logic [7:0] m_row  [BANKS][ROWS];
  logic       m_par  [BANKS][ROWS];
  logic [7:0] m_err;
  bit m_done, m_acc, m_beat, exp_rv;
  int m_bank, m_slot, a, b, r;
  logic [DATA_W-1:0] exp_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done = 0; m_bank = 0; m_slot = 0; m_err = 0; exp_rv = 0; exp_rd = 0;
    end else begin
      m_acc  = req_valid && m_done;
      m_beat = ld_valid && !m_done;
      exp_rv = m_acc;
      exp_rd = 0;
      if (m_acc) begin
        a = int'(req_addr);
        if (a == 0) begin
          if (req_write) m_err = m_err & ~req_wdata[7:0];
          else exp_rd = DATA_W'(m_err);
        end else if (a >= BANKS && a < 2 * BANKS) begin
          if (req_write) m_err = m_err | 8'h08;
          else exp_rd = DATA_W'(m_prot[a - BANKS]);
        end else if (a >= (1 << RB) && a < (2 << RB)) begin
          b = (a - (1 << RB)) / ROWS;
          r = (a - (1 << RB)) % ROWS;
          if (req_write) begin
            if (m_prot[b][6]) m_err = m_err | 8'h20;
            else begin m_row[b][r] = req_wdata[7:0]; m_par[b][r] = ^req_wdata[7:0]; end
          end else if (m_prot[b][5]) begin
            m_err = m_err | 8'h10;
          end else begin
            exp_rd = DATA_W'(m_row[b][r]);
            if ((^m_row[b][r]) != m_par[b][r]) m_err = m_err | 8'h02;
          end
        end else if (req_write) begin
          m_err = m_err | 8'h08;
        end
      end
      if (m_beat) begin
        if (m_slot == 0) m_prot[m_bank] = ld_data;
        else begin m_row[m_bank][m_slot-1] = ld_data; m_par[m_bank][m_slot-1] = ld_par; end
        if (m_slot == ROWS) begin
          m_slot = 0;
          if (m_bank == BANKS - 1) m_done = 1; else m_bank++;
        end else m_slot++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 req_ready", DATA_W'(req_ready), DATA_W'(m_done));
      chk("R1 ld_ready", DATA_W'(ld_ready), DATA_W'(!m_done));
      chk("R3 rsp_valid", DATA_W'(rsp_valid), DATA_W'(exp_rv));
      if (exp_rv) chk("R3 rsp_rdata", rsp_rdata, exp_rd);
    end
  end

  task automatic access(bit wr, int addr, logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd);
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = rsp_rdata;
  endtask

  function automatic int row_addr(int bk, int rw);
    return (1 << RB) + bk * ROWS + rw;
  endfunction

  logic [DATA_W-1:0] d;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset req_ready", DATA_W'(req_ready), 0);
    chk("R1 reset ld_ready", DATA_W'(ld_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid idle", DATA_W'(rsp_valid), 0);
    // R2: load with gaps, bank 0 prot 0x00, bank 1 OP, bank 2 RP, bank 3 WP+SP
    for (int bk = 0; bk < BANKS; bk++) begin
      for (int s = 0; s <= ROWS; s++) begin
        ld_valid = 1'b1;
        if (s == 0) begin
          ld_data = (bk == 0) ? 8'h00 : (bk == 1) ? 8'h40 : (bk == 2) ? 8'h20 : 8'h88;
          ld_par = 1'b1;
        end else begin
          ld_data = fdat(bk, s - 1);
          ld_par = ^fdat(bk, s - 1);
          if ((bk == 0 && s - 1 == 3) || (bk == 2 && s - 1 == 1)) ld_par = ~ld_par;
        end
        @(negedge clk);
        ld_valid = 1'b0;
        if (s % 2 == 0) @(negedge clk);
      end
    end
    chk("R1 load done ld_ready", DATA_W'(ld_ready), 0);
    chk("R1 load done req_ready", DATA_W'(req_ready), 1);
    access(0, row_addr(0, 0), 0, d); chk("R2 bank0 row0", d, DATA_W'(fdat(0, 0)));
    access(0, row_addr(3, 7), 0, d); chk("R11 bank3 row7 WP+SP readable", d, DATA_W'(fdat(3, 7)));
    access(0, BANKS + 1, 0, d); chk("R4 prot bank1", d, 32'h40);
    access(0, BANKS + 3, 0, d); chk("R2 prot bank3", d, 32'h88);
    access(0, 1, 0, d); chk("R4 unmapped read", d, 0);
    access(0, 0, 0, d); chk("R10 err clean", d, 0);
    // R8 parity
    access(0, row_addr(0, 3), 0, d); chk("R8 bad parity data", d, DATA_W'(fdat(0, 3)));
    access(0, 0, 0, d); chk("R8 parity err bit1", d, 32'h02);
    access(1, 0, 32'h02, d); chk("R3 write rsp zero", d, 0);
    access(0, 0, 0, d); chk("R10 cleared", d, 0);
    // R5 read protect
    access(0, row_addr(2, 1), 0, d); chk("R5 rp data zero", d, 0);
    access(0, 0, 0, d); chk("R5 rp err bit4 no parity", d, 32'h10);
    access(1, 0, 32'h00, d);
    access(0, 0, 0, d); chk("R10 zero write keeps", d, 32'h10);
    access(1, 0, 32'hFFFF_FFFF, d);
    access(0, 0, 0, d); chk("R10 all clear", d, 0);
    // R6 override protect
    access(1, row_addr(1, 2), 32'hAB, d);
    access(0, row_addr(1, 2), 0, d); chk("R6 refused row unchanged", d, DATA_W'(fdat(1, 2)));
    access(0, 0, 0, d); chk("R6 op err bit5", d, 32'h20);
    access(1, 0, 32'h20, d);
    // R7 override
    access(1, row_addr(0, 4), 32'hFFFF_FF5C, d);
    access(0, row_addr(0, 4), 0, d); chk("R7 override value", d, 32'h5C);
    access(1, row_addr(0, 3), 32'h77, d);
    access(0, row_addr(0, 3), 0, d); chk("R7 override fixes parity", d, 32'h77);
    access(1, row_addr(3, 0), 32'h3E, d);
    access(0, row_addr(3, 0), 0, d); chk("R11 override on WP bank", d, 32'h3E);
    access(0, 0, 0, d); chk("R8 no err after override", d, 0);
    // R9 locked writes
    access(1, BANKS + 0, 32'hFF, d);
    access(0, BANKS + 0, 0, d); chk("R9 prot unchanged", d, 0);
    access(0, 0, 0, d); chk("R9 lock err bit3", d, 32'h08);
    access(1, 0, 32'h08, d);
    access(1, 100, 32'h12, d);
    access(0, 0, 0, d); chk("R9 unmapped write err", d, 32'h08);
    access(1, 0, 32'h08, d);
    // R3 back-to-back
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(row_addr(0, 1));
    @(negedge clk);
    chk("R3 b2b first", rsp_rdata, DATA_W'(fdat(0, 1)));
    req_addr = ADDR_W'(row_addr(3, 2));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 b2b second", rsp_rdata, DATA_W'(fdat(3, 2)));
    @(negedge clk);
    chk("R3 no rsp when idle", DATA_W'(rsp_valid), 0);
    repeat (20) @(negedge clk);
    access(0, row_addr(0, 4), 0, d); chk("R7 override persists", d, 32'h5C);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule